// File: doc/BRIEF.md
# Byte Unary ALU

This block is the single-operand arithmetic and logic stage of a small 8-bit microcontroller datapath. The stage takes one operand byte and a 4-bit operation code. From these it forms a result byte. The result covers five kinds of operation:

- logical and carry-fed shifts in both directions
- a sign-preserving right shift
- bitwise inversion
- negation, with and without a carry-in
- increment and decrement

The carry flag that feeds the carry-fed operations is the block's own registered carry. A chain of operations therefore threads the carry from one step to the next.

The result is visible at once on a combinational output. When the enable input is high, the clock edge also loads the result into the accumulator register and updates three registered flags: carry, overflow and zero. The carry rule is unusual. Increment and negation raise carry only on a zero result, and the carry-fed forms also need an incoming carry of 1. Decrement drops carry only when it produces 0xFF. Selecting the operand, decoding instructions and two-operand arithmetic belong to other stages.

Top module: `byte_unary_alu`

## Requirements
- R1: Code 0 shifts left with 0 into bit 0, and code 1 shifts left with the old carry into bit 0. In both cases the old bit 7 goes to carry.
- R2: Code 2 shifts right with 0 into bit 7, and code 3 shifts right with the old carry into bit 7. In both cases the old bit 0 goes to carry.
- R3: Code 4 shifts right and keeps bit 7 at its old value. The old bit 0 goes to carry.
- R4: Code 5 returns the bitwise inverse and leaves the carry and overflow flags as they were.
- R5: Code 6 returns the inverse plus one, with carry set exactly when the result is zero. Code 7 returns the inverse plus the old carry, with carry set only when the result is zero and the old carry was 1.
- R6: Code 8 returns the operand plus one, with carry set exactly when the result is zero. Code 9 returns the operand plus the old carry, with carry set only when the result is zero and the old carry was 1.
- R7: Code 10 returns the operand minus one, with carry cleared when the result is 0xFF and set otherwise.
- R8: For codes 0 to 4 and 6 to 10, overflow is set when the result's sign bit is wrong for the true signed outcome. For shifts, this is when bit 7 changed. For negation, it is an operand of 0x80 with an effective +1. For increment, it is an operand of 0x7F with an effective +1. For decrement, it is an operand of 0x80.
- R9: For codes 0 to 10, the zero flag is set exactly when the 8-bit result is 0.
- R10: With enable high and a code from 0 to 10, the clock edge loads the result into the accumulator. With enable low, the accumulator and all flags hold.
- R11: A synchronous reset clears the accumulator and all three flags, whatever the other inputs are.
- R12: Codes 11 to 15 are reserved. The result output equals the operand, and the accumulator and flags hold even when enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Load strobe for the accumulator and flags |
| op | input | 4 | Operation code |
| opnd | input | DW (8) | Operand byte |
| result | output | DW (8) | Combinational result of the selected operation |
| acc | output | DW (8) | Accumulator register |
| carry | output | 1 | Registered carry flag |
| ovf | output | 1 | Registered overflow flag |
| zero | output | 1 | Registered zero flag |

## Verification
The properties assume that op, opnd and en hold steady across each rising edge and carry no unknown values. They also assume that reset is applied before the first checked cycle, so that every carry-dependent check starts from a defined flag state. The stimulus changes inputs only on the falling edge. It runs every code, including the reserved ones, against every operand value. Before each operation it presets the carry to both 0 and 1 by a shift with a known outcome. Enable is dropped on a fixed subset of operands to show that the registers hold.

// File: rtl/ualu_pkg.sv
package ualu_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_SHL  = 4'd0,
        OP_SHLC = 4'd1,
        OP_SHR  = 4'd2,
        OP_SHRC = 4'd3,
        OP_SHRA = 4'd4,
        OP_NOT  = 4'd5,
        OP_NEG  = 4'd6,
        OP_NEGC = 4'd7,
        OP_INC  = 4'd8,
        OP_INCC = 4'd9,
        OP_DEC  = 4'd10
    } ualu_op_e;

    typedef struct packed {
        logic c;
        logic v;
        logic z;
    } ualu_flags_t;

endpackage

// File: rtl/ualu_shift.sv
module ualu_shift
    import ualu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  x,
    input  logic           cin,
    output logic           hit,
    output logic [DW-1:0]  res,
    output logic           cout,
    output logic           vout
);
    localparam int MSB = DW - 1;

    always_comb begin
        hit  = 1'b1;
        res  = x;
        cout = cin;
        case (op)
            OP_SHL: begin
                res  = {x[MSB-1:0], 1'b0};
                cout = x[MSB];
            end
            OP_SHLC: begin
                res  = {x[MSB-1:0], cin};
                cout = x[MSB];
            end
            OP_SHR: begin
                res  = {1'b0, x[MSB:1]};
                cout = x[0];
            end
            OP_SHRC: begin
                res  = {cin, x[MSB:1]};
                cout = x[0];
            end
            OP_SHRA: begin
                res  = {x[MSB], x[MSB:1]};
                cout = x[0];
            end
            default: hit = 1'b0;
        endcase
        // a shift overflows whenever it alters the sign bit
        vout = x[MSB] ^ res[MSB];
    end

endmodule

// File: rtl/ualu_arith.sv
module ualu_arith
    import ualu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  x,
    input  logic           cin,
    input  logic           vin,
    output logic           hit,
    output logic [DW-1:0]  res,
    output logic           cout,
    output logic           vout
);
    localparam int MSB = DW - 1;
    localparam logic [DW-1:0] ONE  = DW'(1);
    localparam logic [DW-1:0] ALL1 = {DW{1'b1}};

    logic          inv;
    logic [DW-1:0] addend;
    logic [DW-1:0] a_in;
    logic [DW-1:0] sum;
    logic          sum_zero;
    logic          sum_ones;
    logic [DW-1:0] cin_w;

    assign cin_w = {{(DW-1){1'b0}}, cin};

    // one shared adder: optional inversion on the operand, small addend
    always_comb begin
        hit    = 1'b1;
        inv    = 1'b0;
        addend = '0;
        case (op)
            OP_NOT:  inv = 1'b1;
            OP_NEG:  begin inv = 1'b1; addend = ONE;   end
            OP_NEGC: begin inv = 1'b1; addend = cin_w; end
            OP_INC:  addend = ONE;
            OP_INCC: addend = cin_w;
            OP_DEC:  addend = ALL1;
            default: hit = 1'b0;
        endcase
        a_in     = inv ? ~x : x;
        sum      = a_in + addend;
        sum_zero = (sum == '0);
        sum_ones = &sum;
        res      = sum;
    end

    always_comb begin
        cout = cin;
        vout = vin;
        case (op)
            OP_NEG: begin
                cout = sum_zero;
                vout = x[MSB] & sum[MSB];
            end
            OP_NEGC: begin
                cout = sum_zero & cin;
                vout = x[MSB] & sum[MSB];
            end
            OP_INC: begin
                cout = sum_zero;
                vout = ~x[MSB] & sum[MSB];
            end
            OP_INCC: begin
                cout = sum_zero & cin;
                vout = ~x[MSB] & sum[MSB];
            end
            OP_DEC: begin
                cout = ~sum_ones;
                vout = x[MSB] & ~sum[MSB];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/byte_unary_alu.sv
module byte_unary_alu
    import ualu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  opnd,
    output logic [DW-1:0]  result,
    output logic [DW-1:0]  acc,
    output logic           carry,
    output logic           ovf,
    output logic           zero
);
    typedef struct packed {
        logic [DW-1:0] acc;
        ualu_flags_t   fl;
    } alu_state_t;

    alu_state_t st_d, st_q;

    logic          sh_hit, ar_hit;
    logic [DW-1:0] sh_res, ar_res;
    logic          sh_c, sh_v, ar_c, ar_v;
    logic [DW-1:0] unit_res;
    logic          unit_c, unit_v, legal;

    ualu_shift #(.DW(DW)) u_shift (
        .op   (op),
        .x    (opnd),
        .cin  (st_q.fl.c),
        .hit  (sh_hit),
        .res  (sh_res),
        .cout (sh_c),
        .vout (sh_v)
    );

    ualu_arith #(.DW(DW)) u_arith (
        .op   (op),
        .x    (opnd),
        .cin  (st_q.fl.c),
        .vin  (st_q.fl.v),
        .hit  (ar_hit),
        .res  (ar_res),
        .cout (ar_c),
        .vout (ar_v)
    );

    always_comb begin
        legal = sh_hit | ar_hit;
        if (sh_hit) begin
            unit_res = sh_res;
            unit_c   = sh_c;
            unit_v   = sh_v;
        end else if (ar_hit) begin
            unit_res = ar_res;
            unit_c   = ar_c;
            unit_v   = ar_v;
        end else begin
            unit_res = opnd;
            unit_c   = st_q.fl.c;
            unit_v   = st_q.fl.v;
        end

        st_d = st_q;
        if (en && legal) begin
            st_d.acc  = unit_res;
            st_d.fl.c = unit_c;
            st_d.fl.v = unit_v;
            st_d.fl.z = (unit_res == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = unit_res;
    assign acc    = st_q.acc;
    assign carry  = st_q.fl.c;
    assign ovf    = st_q.fl.v;
    assign zero   = st_q.fl.z;

endmodule

// File: rtl/ualu_chk.sv
module ualu_chk
    import ualu_pkg::*;
#(
    parameter int DW = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           en,
    input logic [OPW-1:0] op,
    input logic [DW-1:0]  opnd,
    input logic [DW-1:0]  result,
    input logic [DW-1:0]  acc,
    input logic           carry,
    input logic           ovf,
    input logic           zero
);
    localparam logic [DW-1:0] SIGN_ONLY = {1'b1, {(DW-1){1'b0}}};

    logic legal;
    assign legal = (op <= OP_DEC);

    p_shl_carry_r1: assert property (@(posedge clk) disable iff (rst)
        en && (op == OP_SHL || op == OP_SHLC) |=> carry == $past(opnd[DW-1]));

    p_shr_carry_r2: assert property (@(posedge clk) disable iff (rst)
        en && (op == OP_SHR || op == OP_SHRC) |=> carry == $past(opnd[0]));

    p_sra_sign_r3: assert property (@(posedge clk) disable iff (rst)
        en && op == OP_SHRA |=> acc[DW-1] == $past(opnd[DW-1]));

    p_not_keep_r4: assert property (@(posedge clk) disable iff (rst)
        en && op == OP_NOT |=> carry == $past(carry) && ovf == $past(ovf));

    p_neg_carry_r5: assert property (@(posedge clk) disable iff (rst)
        en && op == OP_NEG |=> carry == zero);

    p_inc_carry_r6: assert property (@(posedge clk) disable iff (rst)
        en && op == OP_INC |=> carry == zero);

    p_dec_carry_r7: assert property (@(posedge clk) disable iff (rst)
        en && op == OP_DEC |=> carry == (acc != {DW{1'b1}}));

    p_inc_ovf_r8: assert property (@(posedge clk) disable iff (rst)
        en && op == OP_INC |=> ovf == (acc == SIGN_ONLY));

    p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
        en && legal |=> zero == (acc == '0));

    p_acc_load_r10: assert property (@(posedge clk) disable iff (rst)
        en && legal |=> acc == $past(result));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc) && $stable(carry) && $stable(ovf) && $stable(zero));

    p_rsvd_pass_r12: assert property (@(posedge clk) disable iff (rst)
        !legal |-> result == opnd);

    p_rsvd_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !legal |=> $stable(acc) && $stable(carry) && $stable(ovf) && $stable(zero));

endmodule

bind byte_unary_alu ualu_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .op     (op),
    .opnd   (opnd),
    .result (result),
    .acc    (acc),
    .carry  (carry),
    .ovf    (ovf),
    .zero   (zero)
);

// File: tb/byte_unary_alu_tb.sv
module byte_unary_alu_tb;
    localparam int CLK_P = 10;

    logic       clk;
    logic       rst;
    logic       en;
    logic [3:0] op;
    logic [7:0] opnd;
    logic [7:0] result;
    logic [7:0] acc;
    logic       carry, ovf, zero;

    int errs   = 0;
    int checks = 0;
    int m_acc, m_c, m_v, m_z;

    byte_unary_alu #(.DW(8)) u_dut (
        .clk(clk), .rst(rst), .en(en), .op(op), .opnd(opnd),
        .result(result), .acc(acc), .carry(carry), .ovf(ovf), .zero(zero)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int o);
        case (o)
            0, 1:    return "R1";
            2, 3:    return "R2";
            4:       return "R3";
            5:       return "R4";
            6, 7:    return "R5";
            8, 9:    return "R6";
            10:      return "R7";
            default: return "R12";
        endcase
    endfunction

    // arithmetic reference, written from the requirement text
    task automatic model(input int o, input int x, input int ci, input int vo,
                         output int r, output int c, output int v);
        c = ci;
        v = vo;
        case (o)
            0:  begin r = (x * 2) % 256;       c = (x >= 128); end
            1:  begin r = (x * 2 + ci) % 256;  c = (x >= 128); end
            2:  begin r = x / 2;               c = x % 2; end
            3:  begin r = x / 2 + 128 * ci;    c = x % 2; end
            4:  begin r = x / 2 + ((x >= 128) ? 128 : 0); c = x % 2; end
            5:  r = 255 - x;
            6:  begin r = (256 - x) % 256;      c = (r == 0);         v = (x == 128); end
            7:  begin r = (255 - x + ci) % 256; c = (r == 0 && ci == 1); v = (ci == 1 && x == 128); end
            8:  begin r = (x + 1) % 256;        c = (r == 0);         v = (x == 127); end
            9:  begin r = (x + ci) % 256;       c = (r == 0 && ci == 1); v = (ci == 1 && x == 127); end
            10: begin r = (x + 255) % 256;      c = (r != 255);       v = (x == 128); end
            default: r = x;
        endcase
        if (o <= 4) v = ((x >= 128) != (r >= 128));
    endtask

    task automatic step(input int o, input int x, input bit e);
        int r, c, v;
        bit upd;
        string t;
        @(negedge clk);
        op   = 4'(o);
        opnd = 8'(x);
        en   = e;
        #1;
        model(o, x, m_c, m_v, r, c, v);
        t = tag_of(o);
        chk({t, " result"}, int'(result), r);
        upd = e && (o <= 10);
        @(posedge clk);
        #1;
        if (upd) begin
            m_acc = r; m_c = c; m_v = v; m_z = (r == 0);
            chk("R10 acc", int'(acc), m_acc);
            chk({t, " carry"}, int'(carry), m_c);
            chk("R8 ovf", int'(ovf), m_v);
            chk("R9 zero", int'(zero), m_z);
        end else begin
            t = (o > 10) ? "R12" : "R10";
            chk({t, " hold acc"}, int'(acc), m_acc);
            chk({t, " hold carry"}, int'(carry), m_c);
            chk({t, " hold ovf"}, int'(ovf), m_v);
            chk({t, " hold zero"}, int'(zero), m_z);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; en = 1'b0; op = '0; opnd = '0;
        m_acc = 0; m_c = 0; m_v = 0; m_z = 0;
        repeat (2) @(posedge clk);
        #1;
        chk("R11 reset acc", int'(acc), 0);
        chk("R11 reset carry", int'(carry), 0);
        chk("R11 reset ovf", int'(ovf), 0);
        chk("R11 reset zero", int'(zero), 0);
        @(negedge clk);
        rst = 1'b0;

        // overflow clear, then inversion must keep it clear (R4)
        step(8, 0, 1'b1);
        step(5, 8'h12, 1'b1);

        // full sweep: preset carry by a shift (0x80 -> C=1, 0x40 -> C=0, V=1 both)
        for (int o = 0; o < 16; o++) begin
            for (int x = 0; x < 256; x++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    step(0, (ci == 1) ? 8'h80 : 8'h40, 1'b1);
                    step(o, x, (x % 13) != 5);
                end
            end
        end

        // reset wins over an enabled operation (R11)
        @(negedge clk);
        rst = 1'b1; en = 1'b1; op = 4'd8; opnd = 8'h7F;
        @(posedge clk);
        #1;
        chk("R11 sync reset acc", int'(acc), 0);
        chk("R11 sync reset carry", int'(carry), 0);
        chk("R11 sync reset ovf", int'(ovf), 0);
        chk("R11 sync reset zero", int'(zero), 0);
        @(negedge clk);
        rst = 1'b0; en = 1'b0;
        m_acc = 0; m_c = 0; m_v = 0; m_z = 0;
        step(8, 8'hFF, 1'b1);
        finish_run();
    end

endmodule